// File: doc/BRIEF.md
# General-Purpose I/O Port with Clock-Output Pins

This block is an 8-bit general-purpose I/O port on a simple processor bus. The bus has an address, a write strobe, a read strobe and data in both directions. Software sets up the port through two registers. A direction register makes each pin an input or an output. A data register holds the values that output pins drive. The block drives a value and an output enable for each pad, and it samples each pad level through one register stage.

The two lowest pins are special. When either one is set as an output, it carries a system clock instead of its data bit. Pin 0 carries the phi clock and pin 1 carries the E clock. A read of the data register then shows the clock level at that moment in those bit positions.

The direction register cannot be read back. Hardware standby forces every pad to input at once and clears the direction setting. Software standby changes nothing, so output pins and clock pins keep driving.

Top module: `gpio_clk_port`

## Requirements
- R1: When reset is released, the direction register holds 0x03, the data register holds 0x00 and `pad_oe_o` is 0x03. Pin 0 then drives `sys_clk_i[0]` (the phi clock) and pin 1 drives `sys_clk_i[1]` (the E clock).
- R2: A write strobe at address 0x80 loads the direction register from `bus_wdata_i` at the next rising clock edge. For each bit, 1 makes the pin an output and 0 makes it an input, and `pad_oe_o` equals the direction value. A write to any other address leaves the direction register and the data register unchanged.
- R3: A read at address 0x80 returns 0xFF on `bus_rdata_o`, whatever the direction register holds.
- R4: A write at address 0x82 loads all eight bits of the data register, including bits whose pins are inputs. When any of pins 2 to 7 is later made an output, it drives the stored bit on `pad_out_o`.
- R5: A read at address 0x82 returns, in the same cycle as the read strobe, the stored data bit for each output pin among pins 2 to 7. For each input pin it returns the pad level registered at the previous rising clock edge.
- R6: When pin 0 or pin 1 is an output, its `pad_out_o` bit follows the matching `sys_clk_i` bit instead of the stored data bit.
- R7: A read at address 0x82 while pin 0 or pin 1 is an output returns the current `sys_clk_i` level in that bit position.
- R8: While `hw_stby_i` is high, `pad_oe_o` is 0x00 in the same cycle and writes to the direction register are ignored. After `hw_stby_i` falls, the direction register holds 0x00.
- R9: `sw_stby_i` has no effect. Output enables, stored data and clock outputs keep their behaviour while it is high.
- R10: `bus_rdata_o` is 0x00 when the read strobe is low or the address matches neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_stby_i | input | 1 | Hardware standby request |
| sw_stby_i | input | 1 | Software standby indication |
| sys_clk_i | input | 2 | Clock sources for the clock pins: bit 0 is phi, bit 1 is E |
| bus_addr_i | input | 8 | Register page offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, zero-wait |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 drives the pad |

## Verification
The data-register read is tested with three direction masks. The mask 0xF0 together with pad pattern 0x3C and stored value 0x5A shows whether each bit takes the latched value or the pad level. Clearing all directions shows the pad levels alone. Setting pins 0 and 1 as outputs, and then changing the phi and E levels between reads, shows that the clock replaces the stored bit. A store made while the pins are inputs and then made visible by a later direction change separates a latch that takes every bit from one that takes only the enabled bits. Both standby inputs are also driven with all pins set as outputs, which shows that hardware standby clears the direction register and software standby leaves it alone.

// File: rtl/gpio_clk_pkg.sv
package gpio_clk_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam logic [ADDR_W-1:0] DIR_OFS = 8'h80;
  localparam logic [ADDR_W-1:0] DAT_OFS = 8'h82;
endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int unsigned W   = 8,
  parameter logic [W-1:0] RST = 8'h03
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hw_stby_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o
);
  logic [W-1:0] dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dir_q <= RST;
    else if (hw_stby_i) dir_q <= '0;
    else if (wr_en_i)   dir_q <= wdata_i;
  end

  // standby masks the enables at once; the register clears on the next edge
  assign dir_o = hw_stby_i ? '0 : dir_q;
endmodule

// File: rtl/gpio_dat_reg.sv
module gpio_dat_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] dat_o,
  output logic [W-1:0] pad_sync_o
);
  logic [W-1:0] dat_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dat_q <= '0;
    else if (wr_en_i) dat_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= pad_in_i;
  end

  assign dat_o      = dat_q;
  assign pad_sync_o = sync_q;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W        = 8,
  parameter int unsigned CLK_PINS = 2
) (
  input  logic [W-1:0]        dir_i,
  input  logic [W-1:0]        dat_i,
  input  logic [W-1:0]        pad_sync_i,
  input  logic [CLK_PINS-1:0] sys_clk_i,
  output logic [W-1:0]        pad_out_o,
  output logic [W-1:0]        rd_val_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i < CLK_PINS) begin : g_clk
      assign pad_out_o[i] = dir_i[i] ? sys_clk_i[i] : dat_i[i];
      assign rd_val_o[i]  = dir_i[i] ? sys_clk_i[i] : pad_sync_i[i];
    end else begin : g_dat
      assign pad_out_o[i] = dat_i[i];
      assign rd_val_o[i]  = dir_i[i] ? dat_i[i] : pad_sync_i[i];
    end
  end
endmodule

// File: rtl/gpio_clk_port.sv
module gpio_clk_port #(
  parameter int unsigned W        = 8,
  parameter int unsigned CLK_PINS = 2,
  parameter int unsigned ADDR_W   = gpio_clk_pkg::ADDR_W,
  parameter logic [W-1:0] DIR_RST = 8'h03,
  parameter logic [ADDR_W-1:0] DIR_ADDR = gpio_clk_pkg::DIR_OFS,
  parameter logic [ADDR_W-1:0] DAT_ADDR = gpio_clk_pkg::DAT_OFS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_stby_i,
  input  logic                sw_stby_i,
  input  logic [CLK_PINS-1:0] sys_clk_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [W-1:0]        bus_wdata_i,
  output logic [W-1:0]        bus_rdata_o,
  input  logic [W-1:0]        pad_in_i,
  output logic [W-1:0]        pad_out_o,
  output logic [W-1:0]        pad_oe_o
);
  logic          dir_sel, dat_sel;
  logic [W-1:0]  dir, dat, pad_sync, rd_val;
  logic          sw_stby_unused;

  // software standby keeps all port state as is
  assign sw_stby_unused = sw_stby_i;

  assign dir_sel = (bus_addr_i == DIR_ADDR);
  assign dat_sel = (bus_addr_i == DAT_ADDR);

  gpio_dir_reg #(.W(W), .RST(DIR_RST)) u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_stby_i(hw_stby_i),
    .wr_en_i  (bus_wr_i && dir_sel),
    .wdata_i  (bus_wdata_i),
    .dir_o    (dir)
  );

  gpio_dat_reg #(.W(W)) u_dat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bus_wr_i && dat_sel),
    .wdata_i   (bus_wdata_i),
    .pad_in_i  (pad_in_i),
    .dat_o     (dat),
    .pad_sync_o(pad_sync)
  );

  gpio_pin_mux #(.W(W), .CLK_PINS(CLK_PINS)) u_mux (
    .dir_i     (dir),
    .dat_i     (dat),
    .pad_sync_i(pad_sync),
    .sys_clk_i (sys_clk_i),
    .pad_out_o (pad_out_o),
    .rd_val_o  (rd_val)
  );

  assign pad_oe_o = dir;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      if (dir_sel)      bus_rdata_o = '1;
      else if (dat_sel) bus_rdata_o = rd_val;
    end
  end
endmodule

// File: rtl/gpio_clk_port_chk.sv
module gpio_clk_port_chk #(
  parameter int unsigned W        = 8,
  parameter int unsigned CLK_PINS = 2,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h80
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hw_stby_i,
  input logic                bus_wr_i,
  input logic                bus_rd_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [W-1:0]        bus_rdata_o,
  input logic [W-1:0]        pad_oe_o,
  input logic [CLK_PINS-1:0] clk_pin_out,
  input logic [CLK_PINS-1:0] sys_clk_i
);
  AST_HWSTBY_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |-> pad_oe_o == '0); // R8

  AST_HWSTBY_EXIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hw_stby_i) |-> pad_oe_o == '0); // R8

  AST_DIR_READS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == DIR_ADDR) |-> bus_rdata_o == '1); // R3

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> bus_rdata_o == '0); // R10

  AST_OE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_i && !hw_stby_i) |=> (hw_stby_i || $stable(pad_oe_o))); // R2

  for (genvar i = 0; i < CLK_PINS; i++) begin : g_clk_chk
    AST_CLK_PIN_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_oe_o[i] |-> clk_pin_out[i] == sys_clk_i[i]); // R6
  end
endmodule

bind gpio_clk_port gpio_clk_port_chk #(
  .W(W), .CLK_PINS(CLK_PINS), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_stby_i  (hw_stby_i),
  .bus_wr_i   (bus_wr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .pad_oe_o   (pad_oe_o),
  .clk_pin_out(pad_out_o[CLK_PINS-1:0]),
  .sys_clk_i  (sys_clk_i)
);

// File: tb/gpio_clk_port_tb_top.sv
`timescale 1ns/1ps
module gpio_clk_port_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       hw_stby = 0, sw_stby = 0;
  logic [1:0] sclk = 2'b00;
  logic [7:0] addr = 0, wdata = 0, pad_in = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] rdata, pad_out, pad_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_clk_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_stby_i(hw_stby), .sw_stby_i(sw_stby),
    .sys_clk_i(sclk), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; addr = 0;
    #0.5;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1 d = rdata;
    rd = 0; addr = 0;
  endtask

  // expected data-register read from the requirements (R5, R7)
  function automatic logic [7:0] exp_rd(input logic [7:0] dir, input logic [7:0] dr,
                                         input logic [7:0] pin, input logic [1:0] ck);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = dir[i] ? ((i < 2) ? ck[i] : dr[i]) : pin[i];
    return r;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R1 oe", pad_oe, 8'h03);
    @(negedge clk); sclk = 2'b01;
    #1 check("R1 clock pins", {6'b0, pad_out[1:0]}, 8'h01);
    bus_rd(8'h82, d);
    check("R1 data read", d, exp_rd(8'h03, 8'h00, 8'hA4, 2'b01));
    check("R1 stored data", {pad_out[7:2], 2'b00}, 8'h00);
  endtask

  task automatic t_dir_and_data();
    logic [7:0] d;
    bus_wr(8'h80, 8'hF0);
    check("R2 oe after write", pad_oe, 8'hF0);
    bus_rd(8'h80, d);
    check("R3 dir reads ones", d, 8'hFF);
    bus_wr(8'h82, 8'h5A);
    check("R4 pad_out", {pad_out[7:2], 2'b00}, 8'h58);
    pad_in = 8'h3C;
    @(negedge clk);
    bus_rd(8'h82, d);
    check("R5 mixed read", d, exp_rd(8'hF0, 8'h5A, 8'h3C, sclk));
    bus_wr(8'h84, 8'h00);
    check("R2 stray write oe", pad_oe, 8'hF0);
    check("R2 stray write data", {pad_out[7:2], 2'b00}, 8'h58);
  endtask

  task automatic t_latent_store();
    bus_wr(8'h80, 8'h00);
    check("R2 all inputs", pad_oe, 8'h00);
    bus_wr(8'h82, 8'hC3);
    bus_wr(8'h80, 8'hFC);
    check("R4 latent bits driven", {pad_out[7:2], 2'b00}, 8'hC0);
    check("R4 input-time bits", {6'b0, pad_out[1:0]}, 8'h03);
  endtask

  task automatic t_clock_pins();
    logic [7:0] d;
    bus_wr(8'h82, 8'h00);
    bus_wr(8'h80, 8'h03);
    @(negedge clk); sclk = 2'b11;
    #1 check("R6 clocks high", {6'b0, pad_out[1:0]}, 8'h03);
    @(negedge clk); sclk = 2'b10;
    #1 check("R6 phi low", {6'b0, pad_out[1:0]}, 8'h02);
    pad_in = 8'h00;
    @(negedge clk);
    bus_rd(8'h82, d);
    check("R7 read clocks", d, exp_rd(8'h03, 8'h00, 8'h00, 2'b10));
    sclk = 2'b01;
    bus_rd(8'h82, d);
    check("R7 read clocks changed", d, exp_rd(8'h03, 8'h00, 8'h00, 2'b01));
  endtask

  task automatic t_hw_stby();
    logic [7:0] d;
    bus_wr(8'h80, 8'hFF);
    @(negedge clk); hw_stby = 1;
    #1 check("R8 oe drops at once", pad_oe, 8'h00);
    bus_wr(8'h80, 8'hFF);
    check("R8 write ignored", pad_oe, 8'h00);
    @(negedge clk); hw_stby = 0;
    #1 check("R8 cleared after exit", pad_oe, 8'h00);
    pad_in = 8'h96;
    @(negedge clk);
    bus_rd(8'h82, d);
    check("R8 all inputs read", d, 8'h96);
  endtask

  task automatic t_sw_stby();
    bus_wr(8'h80, 8'hFF);
    bus_wr(8'h82, 8'hA5);
    @(negedge clk); sw_stby = 1;
    repeat (4) @(negedge clk);
    sclk = 2'b10;
    #1 check("R9 oe kept", pad_oe, 8'hFF);
    check("R9 data kept", pad_out, 8'hA6);
    @(negedge clk); sclk = 2'b01;
    #1 check("R9 clocks run", {6'b0, pad_out[1:0]}, 8'h01);
    @(negedge clk); sw_stby = 0;
  endtask

  task automatic t_other_reads();
    logic [7:0] d;
    bus_rd(8'h81, d);
    check("R10 unmapped read", d, 8'h00);
    @(negedge clk); addr = 8'h82;
    #1 check("R10 no strobe", rdata, 8'h00);
    addr = 0;
  endtask

  initial begin
    pad_in = 8'hA4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_dir_and_data();
    t_latent_store();
    t_clock_pins();
    t_hw_stby();
    t_sw_stby();
    t_other_reads();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule